// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Select

This block is a 16-bit accumulator attached to one timer input pin. In event-counter mode it adds one for every edge of the chosen polarity on the pin. In gated mode it adds one for every 64th bus cycle while the pin sits at the chosen level. When the gating pulse ends, it sets a sticky flag. Counting wraps at the top of the range and sets a sticky overflow flag. Software can load the count through a write strobe. Each flag clears through its own write-one strobe.

The block also produces the clock enable for the main timer counter. The four choices are:
- the prescaler tick;
- the accumulator's own increment pulse;
- a pulse on each carry out of the low byte of the count;
- a pulse on each full wrap of the count.

The choice is combinational, so a new setting applies in the same cycle it is written. All ports are plain control and status signals. No data stream crosses the edge of the block, so there is no handshake.

Top module: `pacc_top`

## Requirements
- R1: After reset the count is 0, both flags are 0, and `tclk_en` is 0 while `presc_tick` is 0.
- R2: In event mode (`ctl_mode`=0), `ctl_edge`=1 counts rising pin edges and `ctl_edge`=0 counts falling pin edges. Each counted edge adds exactly one, and edges of the other polarity add nothing. A pin change is counted by the third clock edge after it.
- R3: In gated mode (`ctl_mode`=1), the count advances once per 64 cycles while the synchronized pin is at the enabling level. That level is high when `ctl_edge`=0 and low when `ctl_edge`=1. A pulse held for 64·k cycles adds exactly k.
- R4: In gated mode, the trailing edge of the gating pulse sets `edge_flag`. With `ctl_edge`=0 this is a falling edge; with `ctl_edge`=1 it is a rising edge. The flag stays 0 during the pulse.
- R5: While `tmr_en` is 0, the divide-by-64 tick is absent and gated accumulation does not advance.
- R6: When `ctl_en`=1, `ctl_clksel` selects the source of `tclk_en`: 00 is `presc_tick`, 01 is the accumulator increment pulse, 10 is a carry out of count bits [7:0], and 11 is a wrap of the full 16-bit count.
- R7: When `ctl_en`=0, `tclk_en` equals `presc_tick` for any value of `ctl_clksel`, and the count does not change except through a load.
- R8: A change of `ctl_clksel` changes `tclk_en` in the same cycle, with no register in the path.
- R9: An increment from 16'hFFFF gives 0 and sets `ovf_flag`.
- R10: A `cnt_load` strobe writes `cnt_load_val` into the count at the next clock edge. The load wins over a simultaneous increment.
- R11: Both flags are sticky. `clr_edge_flag` clears `edge_flag`, and `clr_ovf_flag` clears `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Accumulator enable |
| ctl_mode | input | 1 | 0 event counting, 1 gated accumulation |
| ctl_edge | input | 1 | Edge or level polarity select |
| ctl_clksel | input | 2 | Timer clock source select |
| tmr_en | input | 1 | Timer enable; runs the divide-by-64 tick |
| presc_tick | input | 1 | Prescaler output tick |
| pin_in | input | 1 | Asynchronous timer input pin |
| cnt_load | input | 1 | Count write strobe |
| cnt_load_val | input | 16 | Value written by `cnt_load` |
| clr_edge_flag | input | 1 | Write-one-to-clear for `edge_flag` |
| clr_ovf_flag | input | 1 | Write-one-to-clear for `ovf_flag` |
| cnt_out | output | 16 | Accumulator count |
| edge_flag | output | 1 | Trailing-edge flag for gated mode |
| ovf_flag | output | 1 | Count wrap flag |
| tclk_en | output | 1 | Clock enable for the main timer counter |

## Verification
Event counting is swept over both polarities with one to four full pulses. Each sweep is followed by a single half-pulse, which separates the counted polarity from the ignored one. Gated mode is driven with pulses of 64, 128 and 192 cycles at each enabling level. Because the length is an exact multiple of 64, the expected count is exact whatever the tick phase. The flag is sampled inside the pulse and after its trailing edge, and a long pulse with the timer disabled must leave the count unchanged. The clock-select paths are checked by counting `tclk_en` pulses while counts are loaded just below the byte boundary and the full-range boundary, so that only the selected division produces exactly one pulse.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic [1:0] {
    TCLK_PRESC    = 2'b00,
    TCLK_ACC      = 2'b01,
    TCLK_DIV_LOW  = 2'b10,
    TCLK_DIV_FULL = 2'b11
  } tclk_sel_e;

  typedef enum logic {
    ACC_EVENT = 1'b0,
    ACC_GATED = 1'b1
  } acc_mode_e;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pin_evt_t;
endpackage

// File: rtl/pacc_pin_sync.sv
module pacc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin,
  output pacc_pkg::pin_evt_t  evt
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign lvl = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  always_comb begin
    evt.level = lvl;
    evt.rise  = lvl & ~prev;
    evt.fall  = ~lvl & prev;
  end
endmodule

// File: rtl/pacc_div64.sv
module pacc_div64 #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [DIV_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (!run) phase <= '0;
    else           phase <= phase + 1'b1;
  end

  assign tick = run & (&phase);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             carry_low,
  output logic             wrap
);
  logic step;

  assign step      = inc & ~load;
  assign carry_low = step & (&cnt[LOW_W-1:0]);
  assign wrap      = step & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pacc_clksel.sv
module pacc_clksel (
  input  logic       acc_en,
  input  logic [1:0] sel,
  input  logic       presc_tick,
  input  logic       acc_clk,
  input  logic       div_low,
  input  logic       div_full,
  output logic       tclk_en
);
  import pacc_pkg::*;
  tclk_sel_e src;

  always_comb begin
    src = acc_en ? tclk_sel_e'(sel) : TCLK_PRESC;
    unique case (src)
      TCLK_PRESC:    tclk_en = presc_tick;
      TCLK_ACC:      tclk_en = acc_clk;
      TCLK_DIV_LOW:  tclk_en = div_low;
      TCLK_DIV_FULL: tclk_en = div_full;
      default:       tclk_en = presc_tick;
    endcase
  end
endmodule

// File: rtl/pacc_top.sv
module pacc_top #(
  parameter int CNT_W       = 16,
  parameter int LOW_W       = 8,
  parameter int DIV_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             ctl_mode,
  input  logic             ctl_edge,
  input  logic [1:0]       ctl_clksel,
  input  logic             tmr_en,
  input  logic             presc_tick,
  input  logic             pin_in,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  input  logic             clr_edge_flag,
  input  logic             clr_ovf_flag,
  output logic [CNT_W-1:0] cnt_out,
  output logic             edge_flag,
  output logic             ovf_flag,
  output logic             tclk_en
);
  import pacc_pkg::*;

  pin_evt_t  evt;
  acc_mode_e mode;
  logic      div_tick;
  logic      gate_on;
  logic      ev_hit;
  logic      inc;
  logic      trail;
  logic      carry_low;
  logic      wrap;

  pacc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .evt(evt)
  );

  pacc_div64 #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(tmr_en), .tick(div_tick)
  );

  always_comb begin
    mode    = acc_mode_e'(ctl_mode);
    gate_on = ctl_edge ? ~evt.level : evt.level;
    ev_hit  = ctl_edge ? evt.rise : evt.fall;
    trail   = ctl_edge ? evt.rise : evt.fall;
    inc     = 1'b0;
    if (ctl_en) begin
      if (mode == ACC_EVENT) inc = ev_hit;
      else                   inc = gate_on & div_tick;
    end
  end

  pacc_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .load(cnt_load),
    .load_val(cnt_load_val), .cnt(cnt_out),
    .carry_low(carry_low), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (ctl_en && mode == ACC_GATED && trail) edge_flag <= 1'b1;
      else if (clr_edge_flag)                   edge_flag <= 1'b0;
      if (wrap)              ovf_flag <= 1'b1;
      else if (clr_ovf_flag) ovf_flag <= 1'b0;
    end
  end

  pacc_clksel u_sel (
    .acc_en(ctl_en), .sel(ctl_clksel), .presc_tick(presc_tick),
    .acc_clk(inc), .div_low(carry_low), .div_full(wrap), .tclk_en(tclk_en)
  );
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic             ctl_mode,
  input logic             tmr_en,
  input logic             presc_tick,
  input logic             cnt_load,
  input logic             clr_edge_flag,
  input logic             clr_ovf_flag,
  input logic [CNT_W-1:0] cnt_out,
  input logic             edge_flag,
  input logic             ovf_flag,
  input logic             tclk_en
);
  assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_load) && cnt_out != $past(cnt_out)) |-> cnt_out == CNT_W'($past(cnt_out) + 1'b1));

  assert_wrap_sets_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_load) && $past(cnt_out) == '1 && cnt_out == '0) |-> ovf_flag);

  assert_disabled_presc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> tclk_en == presc_tick);

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !cnt_load) |=> $stable(cnt_out));

  assert_no_timer_no_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode && !tmr_en && !cnt_load) |=> $stable(cnt_out));

  assert_edge_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !clr_edge_flag) |=> edge_flag);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf_flag) |=> ovf_flag);
endmodule

bind pacc_top pacc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
  .tmr_en(tmr_en), .presc_tick(presc_tick), .cnt_load(cnt_load),
  .clr_edge_flag(clr_edge_flag), .clr_ovf_flag(clr_ovf_flag),
  .cnt_out(cnt_out), .edge_flag(edge_flag), .ovf_flag(ovf_flag),
  .tclk_en(tclk_en)
);

// File: tb/pacc_top_bench.sv
`timescale 1ns/1ps
module pacc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b0, ctl_mode = 1'b0, ctl_edge = 1'b0;
  logic [1:0]  ctl_clksel = 2'b00;
  logic        tmr_en = 1'b0, presc_tick = 1'b0, pin_in = 1'b0;
  logic        cnt_load = 1'b0;
  logic [15:0] cnt_load_val = '0;
  logic        clr_edge_flag = 1'b0, clr_ovf_flag = 1'b0;
  logic [15:0] cnt_out;
  logic        edge_flag, ovf_flag, tclk_en;

  int tests = 0;
  int fails = 0;
  int tclk_seen = 0;
  bit tclk_clear = 1'b0;

  always #2.5 clk = ~clk;

  pacc_top u_pacc_top (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
    .ctl_edge(ctl_edge), .ctl_clksel(ctl_clksel), .tmr_en(tmr_en),
    .presc_tick(presc_tick), .pin_in(pin_in), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .clr_edge_flag(clr_edge_flag),
    .clr_ovf_flag(clr_ovf_flag), .cnt_out(cnt_out), .edge_flag(edge_flag),
    .ovf_flag(ovf_flag), .tclk_en(tclk_en)
  );

  always @(posedge clk) begin
    if (tclk_clear) tclk_seen <= 0;
    else if (tclk_en) tclk_seen <= tclk_seen + 1;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_cnt(input logic [15:0] v);
    cnt_load = 1'b1; cnt_load_val = v;
    cyc(1);
    cnt_load = 1'b0;
  endtask

  task automatic reset_tclk();
    tclk_clear = 1'b1; cyc(1); tclk_clear = 1'b0;
  endtask

  task automatic setup(input logic mode, input logic edg, input logic idle);
    ctl_en = 1'b0; ctl_mode = mode; ctl_edge = edg; pin_in = idle;
    cyc(5);
    ctl_en = 1'b1;
    cyc(1);
  endtask

  task automatic pulse(input logic edg);
    pin_in = edg;  cyc(4);
    pin_in = ~edg; cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 count", cnt_out, 0);
    chk("R1 edge_flag", edge_flag, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 tclk_en", tclk_en, 0);
    tmr_en = 1'b1;

    // R2 event mode sweep over polarity and pulse count
    for (int e = 0; e < 2; e++) begin
      for (int n = 1; n <= 4; n++) begin
        setup(1'b0, e[0], ~e[0]);
        base = cnt_out;
        for (int i = 0; i < n; i++) pulse(e[0]);
        chk($sformatf("R2 edge=%0d pulses=%0d", e, n), cnt_out - base, n);
      end
      base = cnt_out;
      pin_in = e[0]; cyc(4);
      chk($sformatf("R2 edge=%0d counted half", e), cnt_out - base, 1);
      pin_in = ~e[0]; cyc(4);
      chk($sformatf("R2 edge=%0d ignored half", e), cnt_out - base, 1);
    end

    // R7 disabled accumulator ignores edges
    ctl_en = 1'b0; base = cnt_out;
    pulse(1'b1); pulse(1'b0);
    chk("R7 disabled no count", cnt_out, base);

    // R3/R4 gated mode sweep over level and pulse length
    for (int e = 0; e < 2; e++) begin
      for (int k = 1; k <= 3; k++) begin
        setup(1'b1, e[0], e[0]);
        clr_edge_flag = 1'b1; cyc(1); clr_edge_flag = 1'b0;
        base = cnt_out;
        pin_in = ~e[0];
        cyc(64 * k);
        chk($sformatf("R4 edge=%0d k=%0d flag low in pulse", e, k), edge_flag, 0);
        pin_in = e[0];
        cyc(4);
        chk($sformatf("R3 edge=%0d k=%0d count", e, k), cnt_out - base, k);
        chk($sformatf("R4 edge=%0d k=%0d trailing flag", e, k), edge_flag, 1);
        clr_edge_flag = 1'b1; cyc(1); clr_edge_flag = 1'b0;
        chk($sformatf("R11 edge=%0d k=%0d flag cleared", e, k), edge_flag, 0);
      end
    end

    // R5 timer disabled: no gated accumulation
    setup(1'b1, 1'b0, 1'b0);
    tmr_en = 1'b0; base = cnt_out;
    pin_in = 1'b1; cyc(256);
    pin_in = 1'b0; cyc(4);
    chk("R5 no advance with timer off", cnt_out - base, 0);
    tmr_en = 1'b1;

    // R7/R8 clock select combinational paths
    ctl_en = 1'b0; ctl_clksel = 2'b11; presc_tick = 1'b1; #1;
    chk("R7 disabled follows presc high", tclk_en, 1);
    presc_tick = 1'b0; #1;
    chk("R7 disabled follows presc low", tclk_en, 0);
    setup(1'b0, 1'b1, 1'b0);
    ctl_clksel = 2'b00; presc_tick = 1'b1; #1;
    chk("R6 sel00 presc", tclk_en, 1);
    ctl_clksel = 2'b01; #1;
    chk("R8 immediate switch away", tclk_en, 0);
    ctl_clksel = 2'b00; #1;
    chk("R8 immediate switch back", tclk_en, 1);
    presc_tick = 1'b0;
    cyc(1);

    // R6 accumulator clock: one enable per counted edge
    ctl_clksel = 2'b01; reset_tclk();
    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk("R6 sel01 pulses", tclk_seen, 3);

    // R6/R10 low-byte carry
    ctl_clksel = 2'b10; load_cnt(16'h00FE); reset_tclk();
    chk("R10 load value", cnt_out, 16'h00FE);
    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk("R6 sel10 carry pulses", tclk_seen, 1);
    chk("R6 sel10 count", cnt_out, 16'h0101);

    // R6/R9 full wrap
    ctl_clksel = 2'b11; load_cnt(16'hFFFE); reset_tclk();
    chk("R9 ovf still clear", ovf_flag, 0);
    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk("R6 sel11 wrap pulses", tclk_seen, 1);
    chk("R9 wrapped count", cnt_out, 16'h0001);
    chk("R9 ovf set", ovf_flag, 1);
    clr_ovf_flag = 1'b1; cyc(1); clr_ovf_flag = 1'b0;
    chk("R11 ovf cleared", ovf_flag, 0);

    // R10 load beats an increment in the same cycle
    pin_in = 1'b1;
    cyc(2);
    cnt_load = 1'b1; cnt_load_val = 16'h1234;
    cyc(1);
    cnt_load = 1'b0;
    cyc(3);
    chk("R10 load wins", cnt_out, 16'h1234);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule